// File: doc/BRIEF.md
# CAN controller interrupt code encoder

The block gathers the interrupt sources of a CAN controller into one place. Seven coded sources each own a sticky flag and an enable bit: error, transmit buffers 0 to 2, receive buffers 0 and 1, and bus-activity wake-up. An eighth flag records an invalid message. It has its own enable, and it feeds the interrupt request but not the code. Hardware set pulses arrive from the protocol engine and the buffers. Software reaches the flags and enables through a small register port.

The block drives a 3-bit code that names the highest-priority source whose flag and enable are both 1. It also drives one interrupt request line. A handler reads the code and jumps straight to the matching service routine. It then clears the flag by writing a one to it, and the code moves on to the next pending source.

Top module: `canIrqEncoder`

## Requirements
- R1: While rstN is low, all flags, all enables and irq are 0, and irqCode is 000.
- R2: Flag bit positions are ERR=0, TX0=1, TX1=2, TX2=3, RX0=4, RX1=5, WAK=6, IVM=7. evtSet[5:0] map to flag bits 5..0 and invMsgSet maps to bit 7. A pulse held high at a rising edge sets its flag at that edge.
- R3: The register port decodes regAddr on a write. Address 0 clears every flag bit written as 1. Address 2 sets every flag bit written as 1. Address 1 loads the enable register. A read returns the flags at address 0 or 2, the enables at address 1, and {5'b0, irqCode} at address 3.
- R4: When a hardware set and a software clear hit the same flag at the same edge, the flag ends up set.
- R5: The wake flag (bit 6) is set by hardware only when sleepMode, busActivity and the wake enable (as held before the edge) are all 1. Bus activity at any other time has no effect.
- R6: The code values are ERR=001, TX2=010, TX1=011, TX0=100, RX1=101, RX0=110 and WAK=111.
- R7: When several sources are active, the code names the highest one. The order from highest to lowest is ERR, TX0, TX1, TX2, RX0, RX1, WAK.
- R8: A source counts only when its flag and its enable are both 1. With no active source the code is 000. irqCode follows the registered flags and enables in the same cycle they change.
- R9: irq is the OR of all active sources, including IVM, delayed by one register stage.
- R10: The IVM flag never changes irqCode.
- R11: The enables read back exactly as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtSet | input | 6 | Hardware set pulses for ERR, TX0, TX1, TX2, RX0, RX1 |
| invMsgSet | input | 1 | Hardware set pulse for the invalid-message flag |
| busActivity | input | 1 | Bus activity detected |
| sleepMode | input | 1 | Controller is asleep |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| irqCode | output | 3 | Code of the highest-priority active source |
| irq | output | 1 | Registered interrupt request |

## Verification
A hardware set pulse and a software write-one-to-clear can land on the same flag at the same edge. The set must win, otherwise an event is lost. The bench provokes this in a directed test on the error flag. It also provokes it with random set pulses mixed with random clear masks. In each case a bench model computes the flag value, the code and the delayed request, and judges the result against them.

// File: rtl/canIrqPkg.sv
package canIrqPkg;
  localparam int NUM_FLAGS = 8;
  localparam int NUM_SRC   = 7;
  localparam int NUM_EVT   = 6;
  localparam int CODE_W    = 3;
  localparam int ADDR_W    = 2;
  localparam int WAK_IDX   = 6;
  localparam int IVM_IDX   = 7;

  localparam logic [ADDR_W-1:0] ADDR_CLR  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SET  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CODE = 2'd3;

  // code per source, sources listed from highest to lowest priority
  localparam logic [CODE_W-1:0] SRC_CODE [NUM_SRC] =
    '{3'd1, 3'd4, 3'd3, 3'd2, 3'd6, 3'd5, 3'd7};

  typedef struct packed {
    logic [NUM_FLAGS-1:0] clrMask;
    logic [NUM_FLAGS-1:0] setMask;
    logic                 enLoad;
    logic [NUM_FLAGS-1:0] enData;
  } ctrlStrobes_t;
endpackage

// File: rtl/canIrqCtrl.sv
module canIrqCtrl
  import canIrqPkg::*;
(
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] regWdata,
  output ctrlStrobes_t         strb
);
  always_comb begin
    strb         = '0;
    strb.enData  = regWdata;
    if (regWrite) begin
      unique case (regAddr)
        ADDR_CLR: strb.clrMask = regWdata;
        ADDR_SET: strb.setMask = regWdata;
        ADDR_EN:  strb.enLoad  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/canIrqData.sv
module canIrqData
  import canIrqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [NUM_EVT-1:0]   evtSet,
  input  logic                 invMsgSet,
  input  logic                 busActivity,
  input  logic                 sleepMode,
  input  logic [ADDR_W-1:0]    regAddr,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic [NUM_FLAGS-1:0] enVec,
  output logic [CODE_W-1:0]    irqCode,
  output logic                 irq,
  output logic [NUM_FLAGS-1:0] regRdata
);
  logic [NUM_FLAGS-1:0] hwSet;
  logic [NUM_FLAGS-1:0] activeVec;

  always_comb begin
    hwSet                = '0;
    hwSet[NUM_EVT-1:0]   = evtSet;
    hwSet[WAK_IDX]       = sleepMode & busActivity & enVec[WAK_IDX];
    hwSet[IVM_IDX]       = invMsgSet;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagVec[i] <= 1'b0;
      else       flagVec[i] <= (flagVec[i] & ~strb.clrMask[i]) | strb.setMask[i] | hwSet[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enVec <= '0;
    else if (strb.enLoad) enVec <= strb.enData;
  end

  assign activeVec = flagVec & enVec;

  always_comb begin
    irqCode = '0;
    for (int p = NUM_SRC - 1; p >= 0; p--) begin
      if (activeVec[p]) irqCode = SRC_CODE[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |activeVec;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_EN:   regRdata = enVec;
      ADDR_CODE: regRdata = {{(NUM_FLAGS-CODE_W){1'b0}}, irqCode};
      default:   regRdata = flagVec;
    endcase
  end
endmodule

// File: rtl/canIrqEncoder.sv
module canIrqEncoder
  import canIrqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_EVT-1:0]   evtSet,
  input  logic                 invMsgSet,
  input  logic                 busActivity,
  input  logic                 sleepMode,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_FLAGS-1:0] regWdata,
  output logic [NUM_FLAGS-1:0] regRdata,
  output logic [CODE_W-1:0]    irqCode,
  output logic                 irq
);
  ctrlStrobes_t         strb;
  logic [NUM_FLAGS-1:0] flagVec;
  logic [NUM_FLAGS-1:0] enVec;

  canIrqCtrl u_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strb     (strb)
  );

  canIrqData u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .evtSet      (evtSet),
    .invMsgSet   (invMsgSet),
    .busActivity (busActivity),
    .sleepMode   (sleepMode),
    .regAddr     (regAddr),
    .flagVec     (flagVec),
    .enVec       (enVec),
    .irqCode     (irqCode),
    .irq         (irq),
    .regRdata    (regRdata)
  );
endmodule

// File: rtl/canIrqChecker.sv
module canIrqChecker
  import canIrqPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_EVT-1:0]   evtSet,
  input logic                 busActivity,
  input logic                 sleepMode,
  input logic                 regWrite,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [NUM_FLAGS-1:0] regWdata,
  input logic [NUM_FLAGS-1:0] flagVec,
  input logic [NUM_FLAGS-1:0] enVec,
  input logic [CODE_W-1:0]    irqCode,
  input logic                 irq
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (flagVec == '0 && enVec == '0 && !irq && irqCode == '0));

  assert_set_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[1] |=> flagVec[1]);

  assert_clear_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_CLR && regWdata[2] && !evtSet[2]) |=> !flagVec[2]);

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == ADDR_CLR && regWdata[0] && evtSet[0]) |=> flagVec[0]);

  assert_wake_gated_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!flagVec[WAK_IDX] && !(sleepMode && busActivity && enVec[WAK_IDX]) &&
     !(regWrite && regAddr == ADDR_SET && regWdata[WAK_IDX])) |=> !flagVec[WAK_IDX]);

  assert_err_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec[0] && enVec[0]) |-> irqCode == 3'd1);

  assert_no_code_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((flagVec[NUM_SRC-1:0] & enVec[NUM_SRC-1:0]) == '0) |-> irqCode == '0);

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|(flagVec & enVec)) |=> irq);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(|(flagVec & enVec)) |=> !irq);
endmodule

bind canIrqEncoder canIrqChecker u_chk (.*);

// File: tb/test_canIrqEncoder.sv
`timescale 1ns/1ps
module test_canIrqEncoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] evtSet = '0;
  logic       invMsgSet = 1'b0;
  logic       busActivity = 1'b0;
  logic       sleepMode = 1'b0;
  logic       regWrite = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [2:0] irqCode;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] mFlag = '0;
  logic [7:0] mEn = '0;
  logic       mIrq = 1'b0;

  canIrqEncoder i_canIrqEncoder (.*);

  always #10 clk = ~clk;

  function automatic logic [2:0] expCode(input logic [7:0] f, input logic [7:0] e);
    logic [7:0] a;
    a = f & e;
    if (a[0]) return 3'b001;
    if (a[1]) return 3'b100;
    if (a[2]) return 3'b011;
    if (a[3]) return 3'b010;
    if (a[4]) return 3'b110;
    if (a[5]) return 3'b101;
    if (a[6]) return 3'b111;
    return 3'b000;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [5:0] es, input logic ivm, input logic bus, input logic slp,
                      input logic we, input logic [1:0] ad, input logic [7:0] wd);
    logic [7:0] hw, clr, sset;
    evtSet = es; invMsgSet = ivm; busActivity = bus; sleepMode = slp;
    regWrite = we; regAddr = ad; regWdata = wd;
    @(posedge clk);
    hw   = {ivm, slp & bus & mEn[6], es};
    clr  = (we && ad == 2'd0) ? wd : 8'h00;
    sset = (we && ad == 2'd2) ? wd : 8'h00;
    mIrq = |(mFlag & mEn);
    mFlag = (mFlag & ~clr) | sset | hw;
    if (we && ad == 2'd1) mEn = wd;
    @(negedge clk);
    evtSet = '0; invMsgSet = 1'b0; busActivity = 1'b0; regWrite = 1'b0;
  endtask

  task automatic checkAll(input string tagCode);
    check(tagCode, {5'b0, irqCode}, {5'b0, expCode(mFlag, mEn)});
    check("R9 irq", {7'b0, irq}, {7'b0, mIrq});
    regAddr = 2'd0; #1;
    check("R2 flags", regRdata, mFlag);
    regAddr = 2'd1; #1;
    check("R11 enables", regRdata, mEn);
    regAddr = 2'd3; #1;
    check("R3 code read", regRdata, {5'b0, expCode(mFlag, mEn)});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 flags", regRdata, 8'h00);
    check("R1 code", {5'b0, irqCode}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R8: flag without enable is not active
    step(6'b000001, 0, 0, 0, 0, 0, 0); checkAll("R8 disabled flag");
    step(0, 0, 0, 0, 1, 2'd1, 8'hFE);  checkAll("R8 others enabled");
    step(0, 0, 0, 0, 1, 2'd1, 8'hFF);  checkAll("R6 err code");
    step(0, 0, 0, 0, 1, 2'd0, 8'hFF);  checkAll("R3 clear all");
    // R7 ladder from low to high priority
    step(0, 0, 1, 1, 0, 0, 0);         checkAll("R5 wake in sleep");
    step(6'b100000, 0, 0, 0, 0, 0, 0); checkAll("R7 rx1 over wak");
    step(6'b010000, 0, 0, 0, 0, 0, 0); checkAll("R7 rx0 over rx1");
    step(6'b001000, 0, 0, 0, 0, 0, 0); checkAll("R7 tx2");
    step(6'b000100, 0, 0, 0, 0, 0, 0); checkAll("R7 tx1 over tx2");
    step(6'b000010, 0, 0, 0, 0, 0, 0); checkAll("R7 tx0 over tx1");
    step(6'b000001, 0, 0, 0, 0, 0, 0); checkAll("R7 err over tx0");
    // R4: set and clear collide on ERR
    step(6'b000001, 0, 0, 0, 1, 2'd0, 8'h01); checkAll("R4 set wins");
    step(0, 0, 0, 0, 1, 2'd0, 8'h01);  checkAll("R6 tx0 after err clear");
    step(0, 0, 0, 0, 1, 2'd0, 8'hFF);  checkAll("R3 clear all again");
    // R5: bus activity awake, or with wake disabled, is ignored
    step(0, 0, 1, 0, 0, 0, 0);         checkAll("R5 awake ignored");
    step(0, 0, 0, 0, 1, 2'd1, 8'hBF);  checkAll("R11 wake off");
    step(0, 0, 1, 1, 0, 0, 0);         checkAll("R5 disabled ignored");
    // R10: invalid-message flag raises irq but not code
    step(0, 1, 0, 0, 0, 0, 0);         checkAll("R10 ivm code");
    step(0, 0, 0, 0, 0, 0, 0);         checkAll("R10 ivm irq");
    step(0, 0, 0, 0, 1, 2'd2, 8'h48);  checkAll("R3 soft set");
    step(0, 0, 0, 0, 1, 2'd1, 8'h00);  checkAll("R9 irq drop");
    step(0, 0, 0, 0, 0, 0, 0);         checkAll("R9 irq low");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] ad;
      ad = 2'($urandom_range(0, 3));
      step(6'($urandom & $urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom),
           1'($urandom), 1'($urandom), ad, 8'($urandom));
      checkAll("R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule